// File: doc/BRIEF.md
# Deskewing Character Read Assembler

This block rebuilds parallel characters from a multi-track tape read path in which every track delivers its own pulse, with a small track-to-track timing spread. Each track has a deskew delay line. The tap on that line comes from a forward set or a reverse set, chosen by the tape direction. When the delayed trailing edge of a track pulse emerges from the line, it sets the track's bit in an assembly register.

The first bit of a character starts a strobe timer. Its length follows the recording density. While the timer runs, more track bits join the same character. When it expires, the register contents appear on the parallel data outputs. At the same time a read clock pulse of fixed width is driven, and the register is cleared. Bits that arrive while that pulse is out are kept, and they start the next character once the pulse ends. While reading is not permitted, everything is held cleared.

Delays, pulse width and track count are parameters, all counted in clock cycles.

Top module: `rd_char_assembler`

## Requirements
- R1: During and directly after reset, `chr_clk` is 0 and `chr_data` is all zeros.
- R2: A track's event is the falling edge of its input. Suppose the first clock edge that samples the fall is E. A character whose earliest event comes from a track with skew d has `chr_clk` rise S+d+1 edges after E. Here d is that track's entry in `FWD_SKEW` when `dir_fwd`=1, and S is the selected strobe delay.
- R3: With `BIDIR`=1 and `dir_fwd`=0, every track uses its `REV_SKEW` entry instead of its `FWD_SKEW` entry.
- R4: S is `STROBE_HI` when `dens_hi`=1 and `STROBE_LO` when `dens_hi`=0.
- R5: A track event that emerges no later than S edges after the character's first event is part of that character. Bit i of `chr_data` is track i.
- R6: `chr_clk` stays high for exactly `PULSE_W` cycles, unless reading is withdrawn first. `chr_data` holds steady while `chr_clk` is high and is zero while it is low. Both change on the same edge.
- R7: After a character is output, the assembly register starts empty. No bit carries over into the next character unless its own track pulsed again.
- R8: A track event that emerges while `chr_clk` is high is not lost. It is output as the first bit of the next character.
- R9: While `rd_en`=0, track pulses are ignored, pending bits are discarded, and on the next edge `chr_clk` and `chr_data` go to zero.
- R10: Every character output carries at least one set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Reading permitted; low clears all state |
| trk_in | input | NTRK | Per-track pulses, one bit per track |
| dir_fwd | input | 1 | 1 selects forward deskew set, 0 reverse |
| dens_hi | input | 1 | 1 selects the high-density strobe delay |
| chr_data | output | NTRK | Assembled character, valid while chr_clk is high |
| chr_clk | output | 1 | Read clock pulse, PULSE_W cycles wide |

## Verification
The bench measures the latency from each track fall to the read clock, in both directions and at both densities. A design that ignored direction or density would be off by a few cycles, and the bench would catch it. Two pulses are placed exactly on the last edge of the strobe window and one edge past it. A window that is off by one would merge the bits when they should be split, or split them when they should be merged. A bit that arrives during the output pulse must come out as its own next character, so a design that dropped it or folded it into the current character would fail. The bench also withdraws reading in the middle of a character, both before the strobe and during it, to show that stale bits never reappear.

// File: rtl/rdasm_pkg.sv
package rdasm_pkg;

    localparam int CTL_CNT_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_EMIT = 2'd2
    } strobe_st_e;

    typedef struct packed {
        strobe_st_e             st;
        logic [CTL_CNT_W-1:0]   cnt;
    } strobe_ctl_t;

    function automatic logic [CTL_CNT_W-1:0] cycles_to_load(input int unsigned n);
        return CTL_CNT_W'(n - 1);
    endfunction

endpackage

// File: rtl/rdasm_deskew.sv
module rdasm_deskew
    import rdasm_pkg::*;
#(
    parameter int unsigned MAXD  = 8,
    parameter int unsigned DF    = 0,
    parameter int unsigned DR    = 0,
    parameter bit          BIDIR = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic trk,
    input  logic fwd,
    output logic ev
);
    logic            trk_q;
    logic [MAXD:0]   line_q;
    logic            fall;

    assign fall = trk_q & ~trk;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            trk_q  <= 1'b0;
            line_q <= '0;
        end else begin
            trk_q  <= trk;
            line_q <= {line_q[MAXD-1:0], fall};
        end
    end

    generate
        if (BIDIR) begin : g_bidir
            assign ev = fwd ? line_q[DF] : line_q[DR];
        end else begin : g_fwd_only
            logic unused_dir;
            assign unused_dir = fwd;
            assign ev = line_q[DF];
        end
    endgenerate

endmodule

// File: rtl/rdasm_strobe.sv
module rdasm_strobe
    import rdasm_pkg::*;
#(
    parameter int unsigned NTRK      = 7,
    parameter int unsigned STROBE_HI = 6,
    parameter int unsigned STROBE_LO = 10,
    parameter int unsigned PULSE_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [NTRK-1:0] ev,
    input  logic            dens_hi,
    output logic [NTRK-1:0] chr_data,
    output logic            chr_clk
);
    localparam logic [CTL_CNT_W-1:0] HI_LD = cycles_to_load(STROBE_HI);
    localparam logic [CTL_CNT_W-1:0] LO_LD = cycles_to_load(STROBE_LO);
    localparam logic [CTL_CNT_W-1:0] PW_LD = cycles_to_load(PULSE_W);

    strobe_ctl_t            ctl_q;
    logic [NTRK-1:0]        asm_q;
    logic [NTRK-1:0]        data_q;
    logic                   clk_q;
    logic [NTRK-1:0]        acc;
    logic [CTL_CNT_W-1:0]   wait_ld;

    assign acc     = asm_q | ev;
    assign wait_ld = dens_hi ? HI_LD : LO_LD;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ctl_q.st  <= ST_IDLE;
            ctl_q.cnt <= '0;
            asm_q     <= '0;
            data_q    <= '0;
            clk_q     <= 1'b0;
        end else begin
            unique case (ctl_q.st)
                ST_IDLE: begin
                    asm_q <= acc;
                    if (|ev) begin
                        ctl_q.st  <= ST_WAIT;
                        ctl_q.cnt <= wait_ld;
                    end
                end
                ST_WAIT: begin
                    if (ctl_q.cnt == '0) begin
                        ctl_q.st  <= ST_EMIT;
                        ctl_q.cnt <= PW_LD;
                        data_q    <= acc;
                        clk_q     <= 1'b1;
                        asm_q     <= '0;
                    end else begin
                        ctl_q.cnt <= ctl_q.cnt - CTL_CNT_W'(1);
                        asm_q     <= acc;
                    end
                end
                ST_EMIT: begin
                    asm_q <= acc;
                    if (ctl_q.cnt == '0) begin
                        clk_q  <= 1'b0;
                        data_q <= '0;
                        if (|acc) begin
                            ctl_q.st  <= ST_WAIT;
                            ctl_q.cnt <= wait_ld;
                        end else begin
                            ctl_q.st  <= ST_IDLE;
                        end
                    end else begin
                        ctl_q.cnt <= ctl_q.cnt - CTL_CNT_W'(1);
                    end
                end
                default: begin
                    ctl_q.st <= ST_IDLE;
                end
            endcase
        end
    end

    assign chr_data = data_q;
    assign chr_clk  = clk_q;

endmodule

// File: rtl/rd_char_assembler.sv
module rd_char_assembler
    import rdasm_pkg::*;
#(
    parameter int unsigned NTRK      = 7,
    parameter int unsigned MAX_SKEW  = 8,
    parameter bit          BIDIR     = 1'b1,
    parameter int unsigned FWD_SKEW [NTRK] = '{0, 3, 1, 5, 2, 4, 6},
    parameter int unsigned REV_SKEW [NTRK] = '{6, 4, 2, 0, 5, 3, 1},
    parameter int unsigned STROBE_HI = 6,
    parameter int unsigned STROBE_LO = 10,
    parameter int unsigned PULSE_W   = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rd_en,
    input  logic [NTRK-1:0] trk_in,
    input  logic            dir_fwd,
    input  logic            dens_hi,
    output logic [NTRK-1:0] chr_data,
    output logic            chr_clk
);
    logic [NTRK-1:0] ev;

    generate
        for (genvar g = 0; g < NTRK; g++) begin : g_trk
            rdasm_deskew #(
                .MAXD  (MAX_SKEW),
                .DF    (FWD_SKEW[g]),
                .DR    (REV_SKEW[g]),
                .BIDIR (BIDIR)
            ) u_dsk (
                .clk (clk),
                .rst (rst),
                .clr (!rd_en),
                .trk (trk_in[g]),
                .fwd (dir_fwd),
                .ev  (ev[g])
            );
        end
    endgenerate

    rdasm_strobe #(
        .NTRK      (NTRK),
        .STROBE_HI (STROBE_HI),
        .STROBE_LO (STROBE_LO),
        .PULSE_W   (PULSE_W)
    ) u_strobe (
        .clk      (clk),
        .rst      (rst),
        .en       (rd_en),
        .ev       (ev),
        .dens_hi  (dens_hi),
        .chr_data (chr_data),
        .chr_clk  (chr_clk)
    );

endmodule

// File: rtl/rdasm_chk.sv
module rdasm_chk #(
    parameter int unsigned NTRK    = 7,
    parameter int unsigned PULSE_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_en,
    input logic [NTRK-1:0] chr_data,
    input logic            chr_clk
);
    logic [15:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else     run_q <= chr_clk ? run_q + 16'd1 : '0;
    end

    p_data_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !chr_clk |-> chr_data == '0);

    p_data_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (chr_clk && $past(chr_clk)) |-> $stable(chr_data));

    p_pulse_width_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(chr_clk) && $past(rd_en)) |-> run_q == 16'(PULSE_W));

    p_run_bound_r6: assert property (@(posedge clk) disable iff (rst)
        run_q <= 16'(PULSE_W));

    p_char_nonempty_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(chr_clk) |-> chr_data != '0);

    p_permit_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!chr_clk && chr_data == '0));

endmodule

bind rd_char_assembler rdasm_chk #(
    .NTRK    (NTRK),
    .PULSE_W (PULSE_W)
) u_rdasm_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (rd_en),
    .chr_data (chr_data),
    .chr_clk  (chr_clk)
);

// File: tb/rd_char_assembler_test.sv
`timescale 1ns/1ps
module rd_char_assembler_test;
    localparam int NTRK = 7;
    localparam int SHI  = 6;
    localparam int SLO  = 10;
    localparam int PW   = 4;
    localparam int unsigned FSK [NTRK] = '{0, 3, 1, 5, 2, 4, 6};
    localparam int unsigned RSK [NTRK] = '{6, 4, 2, 0, 5, 3, 1};

    typedef struct packed {
        logic [6:0] trk;
        logic       fwd;
        logic       hi;
        logic [6:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{7'b0000001, 1'b1, 1'b1, 7'b0000001},
        '{7'b1000000, 1'b1, 1'b0, 7'b1000000},
        '{7'b0101010, 1'b0, 1'b1, 7'b0101010},
        '{7'b1111111, 1'b1, 1'b0, 7'b1111111},
        '{7'b0010100, 1'b0, 1'b0, 7'b0010100},
        '{7'b1000001, 1'b0, 1'b1, 7'b1000001}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            rd_en = 1'b0;
    logic [NTRK-1:0] trk_in = '0;
    logic            dir_fwd = 1'b1;
    logic            dens_hi = 1'b1;
    logic [NTRK-1:0] chr_data;
    logic            chr_clk;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rd_char_assembler #(
        .NTRK (NTRK), .MAX_SKEW (8), .BIDIR (1'b1),
        .FWD_SKEW (FSK), .REV_SKEW (RSK),
        .STROBE_HI (SHI), .STROBE_LO (SLO), .PULSE_W (PW)
    ) uut (
        .clk (clk), .rst (rst), .rd_en (rd_en), .trk_in (trk_in),
        .dir_fwd (dir_fwd), .dens_hi (dens_hi),
        .chr_data (chr_data), .chr_clk (chr_clk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [6:0] m, output int c);
        @(negedge clk);
        trk_in = m;
        @(negedge clk);
        trk_in = '0;
        c = cyc;
    endtask

    task automatic wait_rise(input int limit, output bit seen, output int at);
        seen = 1'b0;
        at = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (chr_clk) begin
                seen = 1'b1;
                at = cyc;
                break;
            end
        end
    endtask

    task automatic high_len(output int n);
        n = 0;
        while (chr_clk && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic int exp_latency(input logic [6:0] m, input logic fwd, input logic hi);
        int dmin = 1000;
        for (int t = 0; t < NTRK; t++) begin
            if (m[t]) begin
                int d = fwd ? int'(FSK[t]) : int'(RSK[t]);
                if (d < dmin) dmin = d;
            end
        end
        return dmin + (hi ? SHI : SLO) + 2;
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int  c;
        int  at;
        int  n;
        bit  seen;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(chr_clk == 1'b0 && chr_data == '0, "R1 during reset", int'(chr_data), 0);
        rst = 1'b0;
        rd_en = 1'b1;
        @(negedge clk);
        chk(chr_clk == 1'b0 && chr_data == '0, "R1 after reset", int'(chr_data), 0);
        repeat (4) @(negedge clk);

        // R2 R3 R4 R5 R6: table of patterns, directions and densities
        for (int v = 0; v < 6; v++) begin
            dir_fwd = VECS[v].fwd;
            dens_hi = VECS[v].hi;
            repeat (2) @(negedge clk);
            pulse(VECS[v].trk, c);
            wait_rise(60, seen, at);
            chk(seen && (at - c) == exp_latency(VECS[v].trk, VECS[v].fwd, VECS[v].hi),
                "R2/R3/R4 latency", at - c, exp_latency(VECS[v].trk, VECS[v].fwd, VECS[v].hi));
            chk(chr_data == VECS[v].exp, "R5 data", int'(chr_data), int'(VECS[v].exp));
            high_len(n);
            chk(n == PW, "R6 pulse width", n, PW);
            repeat (30) @(negedge clk);
        end

        // R5: second bit on the last edge of the window joins the character
        dir_fwd = 1'b1;
        dens_hi = 1'b1;
        repeat (2) @(negedge clk);
        pulse(7'b0000001, c);
        @(negedge clk);
        pulse(7'b0000010, c);
        wait_rise(40, seen, at);
        chk(seen && chr_data == 7'b0000011, "R5 window edge", int'(chr_data), 3);
        high_len(n);
        wait_rise(40, seen, at);
        chk(!seen, "R7 no extra character", int'(seen), 0);

        // R8: one edge later the bit arrives during the pulse and forms the next character
        pulse(7'b0000001, c);
        repeat (2) @(negedge clk);
        pulse(7'b0000010, c);
        wait_rise(40, seen, at);
        chk(seen && chr_data == 7'b0000001, "R8 first character", int'(chr_data), 1);
        high_len(n);
        wait_rise(40, seen, at);
        chk(seen && chr_data == 7'b0000010, "R8 held bit as next character", int'(chr_data), 2);
        high_len(n);
        repeat (30) @(negedge clk);

        // R9: pulses ignored while reading is not permitted
        rd_en = 1'b0;
        pulse(7'b1111111, c);
        wait_rise(40, seen, at);
        chk(!seen, "R9 pulses ignored", int'(seen), 0);
        rd_en = 1'b1;

        // R9: pending bit discarded when permit drops before the strobe
        repeat (2) @(negedge clk);
        pulse(7'b0000001, c);
        repeat (2) @(negedge clk);
        rd_en = 1'b0;
        repeat (2) @(negedge clk);
        rd_en = 1'b1;
        wait_rise(40, seen, at);
        chk(!seen, "R9 pending discarded", int'(seen), 0);

        // R7 R9: fresh character carries only the new bit
        pulse(7'b0001000, c);
        wait_rise(40, seen, at);
        chk(seen && chr_data == 7'b0001000, "R7/R9 fresh character", int'(chr_data), 8);

        // R9: dropping permit during the pulse clears outputs on the next edge
        rd_en = 1'b0;
        @(negedge clk);
        chk(chr_clk == 1'b0 && chr_data == '0, "R9 clear during pulse", int'(chr_data), 0);
        rd_en = 1'b1;
        repeat (10) @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule